// File: doc/BRIEF.md
# Serial Audio Word Transmitter Without Bit Clock

This block feeds a serial audio DAC that receives only a master clock, a left/right word clock and one data line. Every timing decision is taken from the master clock, which runs at 256 times the frame rate. No bit clock is driven out. Each data bit is held for four master clocks, so the DAC can sample near the middle of every bit.

Software or a waveform engine writes a 16-bit mono sample as two bytes. The block copies the held sample into its shifter only at the start of a frame, so a sample is never split across two frames. At that moment it raises a one-cycle request so that the producer can prepare the next value. Each frame sends the word in the left half, most significant bit first, one bit period after the word clock rises. The rest of the left half and the whole right half are zeros, so a wider DAC reads the missing low bits as zero.

Top module: `ser_audio_tx`

## Requirements
- R1: While reset is asserted, and until the first frame starts, ws_o, sd_o and sample_req_o are 0. The held sample resets to 0x0000, so the first frame carries an all-zero word.
- R2: ws_o first rises 256 clocks after reset is released. From then on it repeats with a period of 256 clocks: high for 128 clocks, then low for 128 clocks.
- R3: sd_o changes only on clocks whose position within the frame is a multiple of 4. Each bit is held for 4 clocks, and the first data bit starts 4 clocks after ws_o rises.
- R4: The frame position is counted from 0 at the first clock with ws_o high. Bit slot s covers positions 4s..4s+3. Slots 1 to 16 carry sample bits 15 down to 0, so slot s carries bit 16-s.
- R5: sd_o is 0 in slot 0, in slots 17 to 31 of the left half, and throughout the right half (mono).
- R6: hi_wr_i loads hi_byte_i into sample bits 15:8, and lo_wr_i loads lo_byte_i into bits 7:0. The bytes can be written separately. The held value is copied into the shifter only on the clock edge that starts a frame. A write that happens on that same edge takes effect in the following frame. A write made during a frame does not change the word being sent.
- R7: sample_req_o is high for exactly one clock, the first clock of each frame, which is also the first clock with ws_o high.
- R8: If no byte is written during a frame, the next frame sends the same sample again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 x frame rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_byte_i | input | 8 | Sample bits 15:8 |
| lo_byte_i | input | 8 | Sample bits 7:0 |
| hi_wr_i | input | 1 | Write strobe for the high byte |
| lo_wr_i | input | 1 | Write strobe for the low byte |
| sample_req_o | output | 1 | One-clock pulse at frame start |
| ws_o | output | 1 | Word clock, high during the left half |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The assertions check on every cycle that the word clock toggles only at frame positions 0 and 128. They also check that the data line changes only on 4-clock bit boundaries, that it stays low whenever the word clock is low, and that the request is a single pulse on each word-clock rise. Only the bench's scenarios can show which bit appears in which slot and which sample a frame carries. Those scenarios cover byte writes made mid-frame, a single byte written alone, a write on the load edge itself, frames with no write that repeat the last sample, and a reset applied mid-run.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  // per-clock strobes, all relative to the next counter value
  typedef struct packed {
    logic frame_start;
    logic bit_tick;
    logic data_slot;
  } tick_t;
endpackage

// File: rtl/audio_frame_timer.sv
module audio_frame_timer
  import audio_tx_pkg::*;
#(
  parameter int CLK_PER_BIT   = 4,
  parameter int BITS_PER_HALF = 32,
  parameter int SAMPLE_W      = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output tick_t tick_o,
  output logic  ws_o
);
  localparam int HALF_CLKS  = CLK_PER_BIT * BITS_PER_HALF;
  localparam int FRAME_CLKS = 2 * HALF_CLKS;
  localparam int CNT_W      = $clog2(FRAME_CLKS);
  localparam int SLOT_W     = $clog2(2 * BITS_PER_HALF);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [SLOT_W-1:0] slot_nxt;

  always_comb begin
    cnt_nxt  = (cnt_q == CNT_W'(FRAME_CLKS - 1)) ? '0 : cnt_q + 1'b1;
    slot_nxt = SLOT_W'(cnt_nxt / CNT_W'(CLK_PER_BIT));
    tick_o.frame_start = (cnt_nxt == '0);
    tick_o.bit_tick    = ((cnt_nxt % CNT_W'(CLK_PER_BIT)) == '0);
    tick_o.data_slot   = (slot_nxt >= SLOT_W'(1)) && (slot_nxt <= SLOT_W'(SAMPLE_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ws_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (tick_o.frame_start)                  ws_o <= 1'b1;
      else if (cnt_nxt == CNT_W'(HALF_CLKS))   ws_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_sample_holder.sv
module audio_sample_holder #(
  parameter int SAMPLE_W = 16,
  parameter int BYTE_W   = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [SAMPLE_W/BYTE_W-1:0]        wr_i,
  input  logic [SAMPLE_W/BYTE_W-1:0][BYTE_W-1:0] byte_i,
  output logic [SAMPLE_W-1:0]               sample_o
);
  localparam int LANES = SAMPLE_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sample_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_i[g]) sample_o[g*BYTE_W +: BYTE_W] <= byte_i[g];
    end
  end
endmodule

// File: rtl/audio_word_shifter.sv
module audio_word_shifter
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tick_t               tick_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sd_o
);
  logic [SAMPLE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      sd_o <= 1'b0;
    end else begin
      if (tick_i.frame_start)
        sh_q <= sample_i;
      else if (tick_i.bit_tick && tick_i.data_slot)
        sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
      // data moves only at bit boundaries; outside data slots pad with zero
      if (tick_i.bit_tick)
        sd_o <= tick_i.data_slot ? sh_q[SAMPLE_W-1] : 1'b0;
    end
  end
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import audio_tx_pkg::*;
#(
  parameter int CLK_PER_BIT   = 4,
  parameter int BITS_PER_HALF = 32,
  parameter int BYTE_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] hi_byte_i,
  input  logic [BYTE_W-1:0] lo_byte_i,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  output logic              sample_req_o,
  output logic              ws_o,
  output logic              sd_o
);
  localparam int SAMPLE_W   = 2 * BYTE_W;
  localparam int HALF_CLKS  = CLK_PER_BIT * BITS_PER_HALF;
  localparam int FRAME_CLKS = 2 * HALF_CLKS;

  tick_t               tick;
  logic [SAMPLE_W-1:0] held;

  audio_frame_timer #(
    .CLK_PER_BIT(CLK_PER_BIT), .BITS_PER_HALF(BITS_PER_HALF), .SAMPLE_W(SAMPLE_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .ws_o(ws_o)
  );

  audio_sample_holder #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i({hi_wr_i, lo_wr_i}),
    .byte_i({hi_byte_i, lo_byte_i}),
    .sample_o(held)
  );

  audio_word_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .sample_i(held), .sd_o(sd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_req_o <= 1'b0;
    else         sample_req_o <= tick.frame_start;
  end
endmodule

// File: rtl/audio_tx_chk.sv
module audio_tx_chk #(
  parameter int FRAME_CLKS  = 256,
  parameter int HALF_CLKS   = 128,
  parameter int CLK_PER_BIT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ws_o,
  input logic sd_o,
  input logic sample_req_o
);
  localparam int CW = $clog2(FRAME_CLKS);
  logic [CW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= (pos_q == CW'(FRAME_CLKS - 1)) ? '0 : pos_q + 1'b1;
  end

  a_r2_ws_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> (pos_q == '0 || pos_q == CW'(HALF_CLKS)));
  a_r2_ws_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws_o) |-> pos_q == '0);
  a_r3_sd_bit_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> (pos_q % CW'(CLK_PER_BIT)) == '0);
  a_r5_right_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ws_o |-> !sd_o);
  a_r7_req_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_req_o |-> $rose(ws_o));
  a_r7_rise_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws_o) |-> sample_req_o);
  a_r7_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_req_o |=> !sample_req_o);
endmodule

bind ser_audio_tx audio_tx_chk #(
  .FRAME_CLKS(FRAME_CLKS), .HALF_CLKS(HALF_CLKS), .CLK_PER_BIT(CLK_PER_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ws_o(ws_o), .sd_o(sd_o), .sample_req_o(sample_req_o)
);

// File: tb/sim_ser_audio_tx.sv
module sim_ser_audio_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hi_b = '0, lo_b = '0;
  logic       hi_w = 1'b0, lo_w = 1'b0;
  logic       req, ws, sd;

  ser_audio_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .hi_byte_i(hi_b), .lo_byte_i(lo_b),
    .hi_wr_i(hi_w), .lo_wr_i(lo_w), .sample_req_o(req), .ws_o(ws), .sd_o(sd)
  );

  always #10 clk = ~clk;

  int unsigned n;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) n <= 0; else n <= n + 1;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [15:0] held = '0, frame_exp = '0, got_word = '0;
  string tag = "R1";

  function automatic logic exp_ws(int unsigned nn);
    return (nn >= 256) && ((nn % 256) < 128);
  endfunction
  function automatic logic exp_sd(int unsigned nn, logic [15:0] w);
    int unsigned s = (nn % 256) / 4;
    if (nn < 256 || s < 1 || s > 16) return 1'b0;
    return w[16 - s];
  endfunction
  function automatic logic exp_req(int unsigned nn);
    return (nn >= 256) && ((nn % 256) == 0);
  endfunction

  task automatic chk(string r, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s n=%0d actual=%0b expected=%0b", r, n, act, exp);
    end
  endtask

  task automatic step(bit hw, bit lw, logic [7:0] hv, logic [7:0] lv);
    int unsigned p, s;
    @(negedge clk);
    p = n % 256;
    s = p / 4;
    if (rst_n) begin
      chk(n < 256 ? "R1" : "R2", ws, exp_ws(n));
      chk(n < 256 ? "R1" : ((s >= 1 && s <= 16) ? "R3/R4" : "R5"), sd, exp_sd(n, frame_exp));
      chk(n < 256 ? "R1" : "R7", req, exp_req(n));
      if (n >= 256 && p % 4 == 2 && s >= 1 && s <= 16) got_word[16 - s] = sd;
      if (n >= 256 && p == 68) begin
        compared++;
        if (got_word !== frame_exp) begin
          mismatched++;
          $display("FAIL %s word actual=%h expected=%h", tag, got_word, frame_exp);
        end
      end
      if (p == 255) frame_exp = held;  // loaded on the coming edge, before this write
    end
    hi_w = hw; lo_w = lw; hi_b = hv; lo_b = lv;
    if (hw) held[15:8] = hv;
    if (lw) held[7:0]  = lv;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic write_at(int unsigned pt, bit hw, bit lw, logic [7:0] hv, logic [7:0] lv);
    while (((n + 1) % 256) != pt) step(1'b0, 1'b0, 8'h00, 8'h00);
    step(hw, lw, hv, lv);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    held = '0; frame_exp = '0;
    #1;
    chk("R1", ws, 1'b0);
    chk("R1", sd, 1'b0);
    chk("R1", req, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", ws, 1'b0);
    chk("R1", sd, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    do_reset();
    tag = "R1"; idle(330);                         // first frame sends zero word
    tag = "R6"; write_at(40, 1, 1, 8'hA5, 8'hC3);  // mid-frame write, current word unchanged
    idle(512);
    tag = "R8"; idle(512);                         // no write: repeat A5C3
    tag = "R6"; write_at(200, 1, 0, 8'h80, 8'h00); // high byte alone -> 80C3
    idle(300);
    write_at(255, 1, 1, 8'hFF, 8'hFF);             // write on load edge -> next frame
    idle(600);
    tag = "R4"; write_at(10, 1, 1, 8'h00, 8'h01);  // LSB only
    idle(600);
    for (int i = 0; i < 20000; i++) begin
      int unsigned r = $urandom;
      step((r % 48) == 0, ((r >> 8) % 48) == 0, 8'($urandom), 8'($urandom));
    end
    write_at(100, 0, 0, 8'h00, 8'h00);
    #2; do_reset();                                // async reset mid-run
    tag = "R1"; idle(330);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule